// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns one write to the software-interrupt trigger register into an interrupt request. The request carries a vector and a mask of target CPUs. The write brings the id of the CPU that issued it and a 32-bit data word. The word carries three things: a 2-bit filter that picks how targets are chosen, an explicit CPU list, and a 4-bit vector.

The mask is built in two steps. First, the filter forms a raw mask relative to the writing CPU. Second, each bit of that mask is cleared when that CPU's private enable for the chosen vector is clear. A request goes out only when the final mask still has a bit set. An unsupported filter code raises a one-cycle error pulse instead of a request.

Top module: `sgi_dispatch`

## Requirements
- R1: The data word is decoded as follows: the filter is in bits 25:24, the CPU list is in bits 23:16 and the vector is in bits 3:0. All other bits have no effect on any output.
- R2: Filter code 0 takes the CPU list as the raw mask. Bit c of the list stands for CPU c.
- R3: Filter code 1 targets every CPU except the writer. The raw mask is the inverse of the writer's one-hot mask.
- R4: Filter code 2 targets only the writing CPU.
- R5: Filter code 3 issues no request. Instead, `errValid` pulses high for exactly one cycle, in the cycle after the write.
- R6: CPU c keeps its mask bit only if `cpuEnable[c*16 + vector]` is 1. The enables are sampled in the cycle of the write.
- R7: When the final mask is zero, `reqValid` stays low and no error is raised.
- R8: `reqValid` is high for exactly the one cycle after each write that yields a request. Writes on back-to-back cycles give requests on back-to-back cycles.
- R9: After reset, `reqValid`, `errValid`, `reqVector` and `reqMask` are all 0.
- R10: `reqVector` and `reqMask` hold the values of the last issued request until the next request is issued.
- R11: A cycle with `wrValid` low changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | A write to the trigger register happens this cycle |
| wrCpu | input | 3 | Id of the CPU making the write |
| wrData | input | 32 | Data word of the write |
| cpuEnable | input | 128 | Private per-CPU enables; bit c*16+v is vector v on CPU c |
| reqValid | output | 1 | One-cycle request strobe |
| reqVector | output | 4 | Vector of the request |
| reqMask | output | 8 | Final target mask of the request |
| errValid | output | 1 | One-cycle pulse for an unsupported filter code |

## Verification
All results are registered once. A write accepted at a rising edge shows its request, vector, mask or error pulse right after that same edge, and the following edge clears the strobes.

The bench drives each write at a falling edge and checks the result at the next falling edge. It then drops `wrValid` and checks again at the following falling edge, which confirms that the pulse is one cycle wide and that the vector and mask are held. The back-to-back case is checked at two consecutive falling edges.

// File: rtl/sgi_dispatch_pkg.sv
package sgi_dispatch_pkg;
  localparam int FILT_LSB = 24;
  localparam int LIST_LSB = 16;
  localparam int LIST_W   = 8;
  localparam int VEC_LSB  = 0;

  typedef enum logic [1:0] {
    FILT_LIST   = 2'd0,
    FILT_OTHERS = 2'd1,
    FILT_SELF   = 2'd2,
    FILT_BAD    = 2'd3
  } filterE;

  typedef struct packed {
    logic capture;
    logic flagErr;
  } ctrlStrobeS;
endpackage

// File: rtl/sgi_datapath.sv
module sgi_datapath
  import sgi_dispatch_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int NUM_VEC  = 16,
  localparam int VEC_W   = $clog2(NUM_VEC),
  localparam int CPU_W   = $clog2(NUM_CPUS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [CPU_W-1:0]            wrCpu,
  input  logic [31:0]                 wrData,
  input  logic [NUM_CPUS*NUM_VEC-1:0] cpuEnable,
  input  ctrlStrobeS                  strobes,
  output filterE                      filter,
  output logic                        maskNonZero,
  output logic [VEC_W-1:0]            reqVector,
  output logic [NUM_CPUS-1:0]         reqMask
);
  logic [VEC_W-1:0]    vecField;
  logic [LIST_W-1:0]   listField;
  logic [NUM_CPUS-1:0] writerHot;
  logic [NUM_CPUS-1:0] rawMask;
  logic [NUM_CPUS-1:0] enBit;
  logic [NUM_CPUS-1:0] finalMask;

  assign vecField  = wrData[VEC_LSB +: VEC_W];
  assign listField = wrData[LIST_LSB +: LIST_W];
  assign filter    = filterE'(wrData[FILT_LSB +: 2]);
  assign writerHot = NUM_CPUS'(1) << wrCpu;

  always_comb begin
    case (filter)
      FILT_LIST:   rawMask = listField[NUM_CPUS-1:0];
      FILT_OTHERS: rawMask = ~writerHot;
      FILT_SELF:   rawMask = writerHot;
      default:     rawMask = '0;
    endcase
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [NUM_VEC-1:0] enSlice;
    assign enSlice  = cpuEnable[c*NUM_VEC +: NUM_VEC];
    assign enBit[c] = enSlice[vecField];

    // R6: a CPU left in the issued mask had the vector enabled at the write
    a_r6_enable_gate: assert property (@(posedge clk) disable iff (!rstN)
      $past(strobes.capture) |-> (!reqMask[c] || $past(enBit[c])));
  end

  assign finalMask   = rawMask & enBit;
  assign maskNonZero = |finalMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqVector <= '0;
      reqMask   <= '0;
    end else if (strobes.capture) begin
      reqVector <= vecField;
      reqMask   <= finalMask;
    end
  end

  // R4: self filter yields exactly the writer's bit
  a_r4_self_only: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.capture) && $past(filter) == FILT_SELF) |-> reqMask == $past(writerHot));

  // R3: others filter never includes the writer
  a_r3_not_writer: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.capture) && $past(filter) == FILT_OTHERS) |-> (reqMask & $past(writerHot)) == '0);

  // R10: held values stay put without a capture
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.capture && rstN) |=> ($stable(reqMask) && $stable(reqVector)));
endmodule

// File: rtl/sgi_control.sv
module sgi_control
  import sgi_dispatch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  filterE     filter,
  input  logic       maskNonZero,
  output ctrlStrobeS strobes,
  output logic       reqValid,
  output logic       errValid
);
  always_comb begin
    strobes.capture = wrValid && (filter != FILT_BAD) && maskNonZero;
    strobes.flagErr = wrValid && (filter == FILT_BAD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqValid <= 1'b0;
      errValid <= 1'b0;
    end else begin
      reqValid <= strobes.capture;
      errValid <= strobes.flagErr;
    end
  end

  // R8: every strobe comes from a write one cycle earlier
  a_r8_req_after_write: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $past(wrValid));

  // R5: error and request never coincide
  a_r5_err_excl: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> !reqValid);

  // R5: error only for the unsupported code
  a_r5_err_code: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> ($past(wrValid) && $past(filter) == FILT_BAD));
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_dispatch_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int NUM_VEC  = 16,
  localparam int VEC_W   = $clog2(NUM_VEC),
  localparam int CPU_W   = $clog2(NUM_CPUS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrValid,
  input  logic [CPU_W-1:0]            wrCpu,
  input  logic [31:0]                 wrData,
  input  logic [NUM_CPUS*NUM_VEC-1:0] cpuEnable,
  output logic                        reqValid,
  output logic [VEC_W-1:0]            reqVector,
  output logic [NUM_CPUS-1:0]         reqMask,
  output logic                        errValid
);
  ctrlStrobeS strobes;
  filterE     filter;
  logic       maskNonZero;

  sgi_datapath #(.NUM_CPUS(NUM_CPUS), .NUM_VEC(NUM_VEC)) dp_i (
    .clk(clk), .rstN(rstN), .wrCpu(wrCpu), .wrData(wrData),
    .cpuEnable(cpuEnable), .strobes(strobes), .filter(filter),
    .maskNonZero(maskNonZero), .reqVector(reqVector), .reqMask(reqMask)
  );

  sgi_control ctl_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .filter(filter),
    .maskNonZero(maskNonZero), .strobes(strobes),
    .reqValid(reqValid), .errValid(errValid)
  );

  // R7: an issued request always names at least one CPU
  a_r7_nonzero_mask: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> reqMask != '0);
endmodule

// File: tb/sgi_dispatch_tb_top.sv
module sgi_dispatch_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrValid = 1'b0;
  logic [2:0]   wrCpu = '0;
  logic [31:0]  wrData = '0;
  logic [127:0] cpuEnable = '0;
  logic         reqValid;
  logic [3:0]   reqVector;
  logic [7:0]   reqMask;
  logic         errValid;

  int checks = 0;
  int fails = 0;
  logic [3:0] lastVec = '0;
  logic [7:0] lastMask = '0;

  always #5 clk = ~clk;

  sgi_dispatch dut_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrCpu(wrCpu), .wrData(wrData),
    .cpuEnable(cpuEnable), .reqValid(reqValid), .reqVector(reqVector),
    .reqMask(reqMask), .errValid(errValid)
  );

  // cpu[52:50] data[49:18] enablesForVector[17:10] expReq[9] expErr[8] expMask[7:0]
  localparam logic [52:0] VECS [10] = '{
    {3'd0, 32'h00A5_0003, 8'hFF, 1'b1, 1'b0, 8'hA5},  // R2 list
    {3'd3, 32'h0100_0007, 8'hFF, 1'b1, 1'b0, 8'hF7},  // R3 others
    {3'd5, 32'h0200_000F, 8'hFF, 1'b1, 1'b0, 8'h20},  // R4 self
    {3'd2, 32'h0300_0004, 8'hFF, 1'b0, 1'b1, 8'h00},  // R5 bad code
    {3'd1, 32'h00FF_0009, 8'h3C, 1'b1, 1'b0, 8'h3C},  // R6 narrowing
    {3'd6, 32'h0100_0002, 8'h40, 1'b0, 1'b0, 8'h00},  // R7 all removed
    {3'd4, 32'h0200_0005, 8'hEF, 1'b0, 1'b0, 8'h00},  // R7 self disabled
    {3'd7, 32'hFCA5_FFF1, 8'h0F, 1'b1, 1'b0, 8'h05},  // R1 junk bits
    {3'd0, 32'h0100_000C, 8'hFF, 1'b1, 1'b0, 8'hFE},  // R3 writer 0
    {3'd3, 32'h0000_0001, 8'hFF, 1'b0, 1'b0, 8'h00}   // R7 empty list
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [127:0] mkEnable(input logic [3:0] vec, input logic [7:0] enm);
    logic [127:0] e;
    for (int c = 0; c < 8; c++)
      for (int v = 0; v < 16; v++)
        e[c*16+v] = (v == int'(vec)) ? enm[c] : ~enm[c];
    return e;
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #100us;
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 reqValid", {31'd0, reqValid}, 0);
    chk("R9 errValid", {31'd0, errValid}, 0);
    chk("R9 reqVector", {28'd0, reqVector}, 0);
    chk("R9 reqMask", {24'd0, reqMask}, 0);

    for (int i = 0; i < 10; i++) begin
      logic [52:0] e;
      e = VECS[i];
      wrCpu = e[52:50];
      wrData = e[49:18];
      cpuEnable = mkEnable(e[21:18], e[17:10]);
      wrValid = 1'b1;
      @(negedge clk);
      wrValid = 1'b0;
      chk($sformatf("R2-vec%0d R7 reqValid", i), {31'd0, reqValid}, {31'd0, e[9]});
      chk($sformatf("R5 vec%0d errValid", i), {31'd0, errValid}, {31'd0, e[8]});
      if (e[9]) begin
        lastVec = e[21:18];
        lastMask = e[7:0];
      end
      chk($sformatf("R1 R6 vec%0d reqVector", i), {28'd0, reqVector}, {28'd0, lastVec});
      chk($sformatf("R6 R10 vec%0d reqMask", i), {24'd0, reqMask}, {24'd0, lastMask});
      wrData = 32'h03FF_FFFF;  // R11 garbage while idle
      @(negedge clk);
      chk($sformatf("R8 vec%0d strobe width", i), {31'd0, reqValid}, 0);
      chk($sformatf("R5 vec%0d err width", i), {31'd0, errValid}, 0);
      chk($sformatf("R11 vec%0d idle mask", i), {24'd0, reqMask}, {24'd0, lastMask});
    end

    // R10: hold after a write that issued nothing
    chk("R10 held vector", {28'd0, reqVector}, 32'hC);
    chk("R10 held mask", {24'd0, reqMask}, 32'hFE);

    // R8: back-to-back writes
    cpuEnable = '1;
    wrCpu = 3'd1; wrData = 32'h0200_0004; wrValid = 1'b1;
    @(negedge clk);
    chk("R8 first req", {31'd0, reqValid}, 1);
    chk("R8 first mask", {24'd0, reqMask}, 32'h02);
    chk("R8 first vector", {28'd0, reqVector}, 32'h4);
    wrCpu = 3'd2; wrData = 32'h0200_0006;
    @(negedge clk);
    wrValid = 1'b0;
    chk("R8 second req", {31'd0, reqValid}, 1);
    chk("R8 second mask", {24'd0, reqMask}, 32'h04);
    chk("R8 second vector", {28'd0, reqVector}, 32'h6);
    @(negedge clk);
    chk("R8 strobe drops", {31'd0, reqValid}, 0);

    // R9: reset clears held values
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R9 mask after reset", {24'd0, reqMask}, 0);
    chk("R9 vector after reset", {28'd0, reqVector}, 0);
    summary();
  end
endmodule